// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block remembers where taken branches went. Fetch logic presents an instruction address on the lookup port and gets back, in the same cycle and without a clock edge in between, a hit flag and the remembered destination. A second address input drives a standalone hit flag, so that another pipeline stage can ask whether an address is tracked without needing a second target path. When a branch resolves, the execution side writes the branch address and its real destination through the update port. The write lands on the next rising clock edge.

Each address maps to exactly one slot. The slot number is taken from the address bits just above the instruction-alignment bits. A tag is kept from the bits just above the slot number, and its width is a parameter. A new write always replaces whatever the slot held. There is no comparison before the write and no choice of victim. On a miss the target output reads zero. The hit flag lets a real stored target of zero be told apart from a miss. Reset invalidates every slot.

Top module: `btb_direct`

## Requirements
- R1: While reset is asserted, and after it is released, every slot reads as invalid until it is written. Every lookup and every query therefore misses.
- R2: The slot number is the address shifted right by OFFSET_SHIFT and then taken modulo ENTRIES. ENTRIES is a power of two; the default is bits [5:2] of the address.
- R3: The stored tag is the TAG_W bits that start directly above the slot field. With the defaults these are address bits [15:6]. Address bits above the tag field are not compared, so addresses that differ only there alias to the same entry.
- R4: A lookup hits only when the indexed slot is valid and its stored tag equals the tag of the presented address. A valid slot holding another tag gives a miss.
- R5: On a hit, the lookup target output equals the target last written to that slot. On a miss it is zero.
- R6: An update always overwrites the indexed slot with the new tag and target and marks it valid, whatever the slot held before.
- R7: An update takes effect at the next rising clock edge. A lookup or query in the same cycle as the update sees the slot's previous contents.
- R8: The query output reports a hit for its own address input under the same rule as R4, independently of the lookup address.
- R9: A stored target of zero is returned with the hit flag high, so it can be told apart from a miss.
- R10: The OFFSET_SHIFT lowest address bits have no effect on lookup, query or update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; updates are written on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| lk_pc | input | ADDR_W | Address presented for lookup |
| lk_hit | output | 1 | Lookup hit flag |
| lk_target | output | ADDR_W | Stored target on a hit, zero on a miss |
| qry_pc | input | ADDR_W | Address presented for the standalone hit query |
| qry_hit | output | 1 | Query hit flag |
| upd_en | input | 1 | Write strobe for the update port |
| upd_pc | input | ADDR_W | Branch address being written |
| upd_target | input | ADDR_W | Destination stored for that branch |

## Verification
A wrong valid bit, tag or target inside the table shows up in the same cycle that an address mapping to that slot is looked up, because the read path has no register. A corrupted slot can stay hidden until fetch touches it. So the stimulus keeps addresses within a small pool of slots and tags, and every slot is revisited often. Faults in slot or tag extraction show as hits where misses are expected, or as the reverse. Aliasing addresses, addresses that differ only in the offset bits, and same-slot tag conflicts expose such faults directly. A write that lands one cycle early or late is caught by looking up the written address in the same cycle as the write and again in the cycle after.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Bit position where the tag field starts, above the offset and slot fields.
  function automatic int tag_lsb(input int offset_shift, input int idx_w);
    return offset_shift + idx_w;
  endfunction
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int ADDR_W       = 32,
  parameter int IDX_W        = 4,
  parameter int OFFSET_SHIFT = 2,
  parameter int TAG_W        = 10
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  localparam int TAG_LSB = btb_pkg::tag_lsb(OFFSET_SHIFT, IDX_W);

  logic [ADDR_W-1:0] pc_idx_sh;
  logic [ADDR_W-1:0] pc_tag_sh;

  always_comb begin
    pc_idx_sh = pc >> OFFSET_SHIFT;
    pc_tag_sh = pc >> TAG_LSB;
    idx       = pc_idx_sh[IDX_W-1:0];
    tag       = pc_tag_sh[TAG_W-1:0];
  end
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 10,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [TAG_W-1:0]               wr_tag,
  input  logic [ADDR_W-1:0]              wr_target,
  output logic [ENTRIES-1:0]             valid_q,
  output logic [ENTRIES-1:0][TAG_W-1:0]  tag_q,
  output logic [ENTRIES-1:0][ADDR_W-1:0] tgt_q
);
  logic [ENTRIES-1:0] wr_sel;
  logic [ENTRIES-1:0] valid_d;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    // next state
    always_comb begin
      wr_sel[e]  = wr_en && (wr_idx == IDX_W'(e));
      valid_d[e] = valid_q[e] | wr_sel[e];
    end

    // valid bit: cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q[e] <= 1'b0;
      else        valid_q[e] <= valid_d[e];
    end

    // payload: plain enable, no reset
    always_ff @(posedge clk) begin
      if (wr_sel[e]) begin
        tag_q[e] <= wr_tag;
        tgt_q[e] <= wr_target;
      end
    end
  end
endmodule

// File: rtl/btb_read_port.sv
module btb_read_port #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 10,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [IDX_W-1:0]               rd_idx,
  input  logic [TAG_W-1:0]               rd_tag,
  input  logic [ENTRIES-1:0]             valid_q,
  input  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tgt_q,
  output logic                           hit,
  output logic [ADDR_W-1:0]              target
);
  always_comb begin
    hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    target = hit ? tgt_q[rd_idx] : '0;
  end
endmodule

// File: rtl/btb_direct.sv
module btb_direct #(
  parameter int ADDR_W       = 32,
  parameter int ENTRIES      = 16,
  parameter int OFFSET_SHIFT = 2,
  parameter int TAG_W        = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic [ADDR_W-1:0] lk_target,
  input  logic [ADDR_W-1:0] qry_pc,
  output logic              qry_hit,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] lk_idx, qry_idx, upd_idx;
  logic [TAG_W-1:0] lk_tag, qry_tag, upd_tag;

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tgt_q;
  logic [ADDR_W-1:0]              qry_target_unused;

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFFSET_SHIFT(OFFSET_SHIFT),
                   .TAG_W(TAG_W)) u_split_lk (.pc(lk_pc), .idx(lk_idx), .tag(lk_tag));
  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFFSET_SHIFT(OFFSET_SHIFT),
                   .TAG_W(TAG_W)) u_split_qry (.pc(qry_pc), .idx(qry_idx), .tag(qry_tag));
  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFFSET_SHIFT(OFFSET_SHIFT),
                   .TAG_W(TAG_W)) u_split_upd (.pc(upd_pc), .idx(upd_idx), .tag(upd_tag));

  btb_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(upd_en), .wr_idx(upd_idx), .wr_tag(upd_tag),
    .wr_target(upd_target), .valid_q(valid_q), .tag_q(tag_q), .tgt_q(tgt_q));

  btb_read_port #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_rd_lk (
    .rd_idx(lk_idx), .rd_tag(lk_tag), .valid_q(valid_q), .tag_q(tag_q), .tgt_q(tgt_q),
    .hit(lk_hit), .target(lk_target));

  btb_read_port #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_rd_qry (
    .rd_idx(qry_idx), .rd_tag(qry_tag), .valid_q(valid_q), .tag_q(tag_q), .tgt_q(tgt_q),
    .hit(qry_hit), .target(qry_target_unused));

  // The query port reports the flag only; its target path is left to trimming.
  logic unused_ok;
  always_comb unused_ok = ^qry_target_unused;
endmodule

// File: rtl/btb_direct_chk.sv
module btb_direct_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              lk_hit,
  input logic [ADDR_W-1:0] lk_target,
  input logic [ADDR_W-1:0] qry_pc,
  input logic              qry_hit,
  input logic              upd_en,
  input logic [ADDR_W-1:0] upd_pc,
  input logic [ADDR_W-1:0] upd_target
);
  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_target == '0);

  // R6
  write_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en ##1 (lk_pc == $past(upd_pc)) |-> lk_hit && lk_target == $past(upd_target));

  // R8
  query_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_pc == lk_pc) |-> qry_hit == lk_hit);

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(upd_en) && $stable(lk_pc) && $past(rst_n)) |-> $stable(lk_hit) && $stable(lk_target));

  logic unused_ok;
  always_comb unused_ok = ^upd_target;
endmodule

bind btb_direct btb_direct_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
  .qry_pc(qry_pc), .qry_hit(qry_hit), .upd_en(upd_en), .upd_pc(upd_pc),
  .upd_target(upd_target));

// File: tb/btb_direct_tb_top.sv
module btb_direct_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NE = 16;
  localparam int SH = 2;
  localparam int TW = 10;
  localparam int IW = 4;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] lk_pc, qry_pc, upd_pc, upd_target, lk_target;
  logic          lk_hit, qry_hit, upd_en;

  int total = 0;
  int bad   = 0;

  bit          m_valid [NE];
  logic [TW-1:0] m_tag [NE];
  logic [AW-1:0] m_tgt [NE];

  btb_direct #(.ADDR_W(AW), .ENTRIES(NE), .OFFSET_SHIFT(SH), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
    .qry_pc(qry_pc), .qry_hit(qry_hit), .upd_en(upd_en), .upd_pc(upd_pc),
    .upd_target(upd_target));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int f_idx(logic [AW-1:0] pc);
    return int'((pc >> SH) % NE);
  endfunction
  function automatic logic [TW-1:0] f_tag(logic [AW-1:0] pc);
    return TW'(pc >> (SH + IW));
  endfunction
  function automatic bit f_hit(logic [AW-1:0] pc);
    return m_valid[f_idx(pc)] && m_tag[f_idx(pc)] == f_tag(pc);
  endfunction
  function automatic logic [AW-1:0] f_tgt(logic [AW-1:0] pc);
    return f_hit(pc) ? m_tgt[f_idx(pc)] : '0;
  endfunction
  function automatic logic [AW-1:0] mk_pc(int tag, int idx, int low);
    return (AW'(tag) << (SH + IW)) | (AW'(idx) << SH) | AW'(low);
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, check lookup and query against the model before the edge,
  // then commit the update to the model after the rising edge.
  task automatic step(string req, bit we, logic [AW-1:0] wpc, logic [AW-1:0] wtg,
                      logic [AW-1:0] lpc, logic [AW-1:0] qpc);
    @(negedge clk);
    upd_en = we; upd_pc = wpc; upd_target = wtg; lk_pc = lpc; qry_pc = qpc;
    #1;
    check({req, " lk_hit"}, AW'(lk_hit), AW'(f_hit(lpc)));
    check({req, " lk_target"}, lk_target, f_tgt(lpc));
    check({req, " qry_hit"}, AW'(qry_hit), AW'(f_hit(qpc)));
    @(posedge clk);
    if (we) begin
      m_valid[f_idx(wpc)] = 1'b1;
      m_tag[f_idx(wpc)]   = f_tag(wpc);
      m_tgt[f_idx(wpc)]   = wtg;
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NE; i++) m_valid[i] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; upd_en = 1'b0; upd_pc = '0; upd_target = '0; lk_pc = '0; qry_pc = '0;
    clear_model();
    repeat (3) @(posedge clk);
    // R1: in reset, every slot misses
    for (int i = 0; i < NE; i++) begin
      lk_pc = mk_pc(0, i, 0); qry_pc = mk_pc(0, i, 0); #1;
      check("R1 reset lk_hit", AW'(lk_hit), '0);
      check("R1 reset qry_hit", AW'(qry_hit), '0);
    end
    @(negedge clk); rst_n = 1'b1;
    // R1: after release, still all miss
    for (int i = 0; i < NE; i++) step("R1 post-reset", 0, '0, '0, mk_pc(5, i, 0), mk_pc(0, i, 0));

    // R7: same-cycle lookup sees old contents, next cycle sees new
    step("R7 same-cycle", 1, mk_pc(3, 2, 0), 32'hCAFE_0000, mk_pc(3, 2, 0), mk_pc(3, 2, 0));
    step("R7 next-cycle R5", 0, '0, '0, mk_pc(3, 2, 0), mk_pc(3, 2, 0));
    check("R7 new target visible", lk_target, 32'hCAFE_0000);
    // R6: overwrite with a different tag; old tag now misses (R4)
    step("R6 overwrite", 1, mk_pc(9, 2, 0), 32'h1234_5678, mk_pc(3, 2, 0), mk_pc(9, 2, 0));
    step("R4 old tag misses", 0, '0, '0, mk_pc(3, 2, 0), mk_pc(9, 2, 0));
    check("R4 old tag lk_hit", AW'(lk_hit), '0);
    check("R6 new tag qry_hit", AW'(qry_hit), 1);
    // R9: zero target is a hit
    step("R9 write zero", 1, mk_pc(7, 5, 0), '0, '0, '0);
    step("R9 zero hit", 0, '0, '0, mk_pc(7, 5, 0), '0);
    check("R9 zero target hit flag", AW'(lk_hit), 1);
    // R10: offset bits ignored
    step("R10 write low bits", 1, mk_pc(4, 6, 3), 32'hAAAA_0004, mk_pc(4, 6, 1), mk_pc(4, 6, 2));
    step("R10 read low bits", 0, '0, '0, mk_pc(4, 6, 2), mk_pc(4, 6, 1));
    check("R10 offset ignored", AW'(lk_hit), 1);
    // R3: bits above the tag field alias; R2: slot from bits [5:2]
    step("R3 alias", 0, '0, '0, mk_pc(4 + (1 << TW), 6, 0), mk_pc(4 + (3 << TW), 6, 0));
    check("R3 alias hits", AW'(lk_hit), 1);
    step("R2 neighbour slot", 0, '0, '0, mk_pc(4, 7, 0), mk_pc(4, 5, 0));
    check("R2 neighbour misses", AW'(lk_hit), '0);

    // R8 and the rest: random mix over a small pool of slots and tags
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] w, l, q;
      w = mk_pc(int'($urandom_range(0, 3)), int'($urandom_range(0, NE - 1)), int'($urandom_range(0, 3)));
      l = mk_pc(int'($urandom_range(0, 3)), int'($urandom_range(0, NE - 1)), int'($urandom_range(0, 3)));
      q = ($urandom_range(0, 3) == 0) ? w : mk_pc(int'($urandom_range(0, 3)), int'($urandom_range(0, NE - 1)), 0);
      step("R8 R4 R5 random", bit'($urandom_range(0, 1)), w, $urandom(), l, q);
    end

    // R1: reset in mid-run drops every entry
    @(negedge clk); rst_n = 1'b0; upd_en = 1'b0; clear_model(); #1;
    check("R1 async clear", AW'(lk_hit), '0);
    @(negedge clk); rst_n = 1'b1;
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < NE; i++) step("R1 after mid reset", 0, '0, '0, mk_pc(t, i, 0), mk_pc(t, i, 1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule